// File: doc/BRIEF.md
# Byte-Select SRAM Bus Interface

This block turns a simple host request port into bus cycles for an external 16-bit asynchronous SRAM that has separate upper-byte and lower-byte select inputs. It drives the halfword address, an active-low chip select, a read strobe, a read/write line, one select per byte lane and a split data bus made of an output, an output enable and an input. The host presents one request at a time: a read or write, halfword or single byte, and a byte address. It receives a one-cycle done pulse when the SRAM cycle has finished. On a read, the returned data is valid in the same cycle as the done pulse.

A configuration bit picks one of two strobe schemes. With the bit clear, the byte selects act as the write strobe, and the read/write line stays low for the whole write. With the bit set, the read/write line acts as the write strobe, the byte selects stay low over the entire access, and a hold count adds cycles after the write strobe during which data is still driven. In both schemes a wait count stretches the strobe window.

An access takes one setup cycle, then `cfg_wait` wait cycles, then one strobe cycle. A write in the second scheme then adds `cfg_hold` hold cycles. Configuration and request fields are sampled when a request is accepted.

Top module: `bsel_sram_if`

## Requirements
- R1: While reset is applied and after reset, with no request, `mem_cs_n`, `mem_rd_n`, `mem_rw_n`, `mem_ub_n` and `mem_lb_n` are 1, and `mem_dq_oe` and `host_done` are 0.
- R2: An accepted request holds `mem_cs_n` at 0 for 2+W cycles, where W is `cfg_wait`. A write with `cfg_rw_strobe`=1 adds H cycles, where H is `cfg_hold`. `host_done` is 1 for exactly the one cycle after the last low cycle of `mem_cs_n`.
- R3: With `cfg_rw_strobe`=0, a write holds `mem_rw_n` at 0 in every access cycle. The selected byte selects are 0 in every cycle except the first (setup) cycle.
- R4: A read holds `mem_rd_n` at 0 in every access cycle except the first, and keeps `mem_rw_n` at 1. With `cfg_rw_strobe`=0, the selected byte selects are 0 in the same cycles as `mem_rd_n`.
- R5: With `cfg_rw_strobe`=1, the selected byte selects are 0 in every cycle in which `mem_cs_n` is 0, for both reads and writes.
- R6: With `cfg_rw_strobe`=1, a write holds `mem_rw_n` at 0 in every access cycle except the setup cycle and the H trailing hold cycles.
- R7: With `host_word`=1, both byte selects are used. With `host_word`=0, `host_addr[0]`=0 selects only `mem_lb_n` and `host_addr[0]`=1 selects only `mem_ub_n`.
- R8: `mem_dq_oe` is 1 in exactly the write access cycles, including hold cycles. While it is 1, `mem_dq_o` equals the accepted `host_wdata`.
- R9: On a read, `host_rdata` equals the value of `mem_dq_i` sampled at the end of the strobe cycle, and is valid while `host_done` is 1.
- R10: While `mem_cs_n` is 0, `mem_addr` equals `host_addr[AW-1:1]` of the accepted request and does not change.
- R11: A `host_req` that arrives while an access is in progress is ignored: the running access keeps its timing, and no new access follows it.
- R12: `cfg_hold` has no effect on reads or when `cfg_rw_strobe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rw_strobe | input | 1 | 0: byte selects are the write strobe; 1: read/write line is the write strobe |
| cfg_wait | input | WAIT_W | Wait cycles inserted before the strobe cycle |
| cfg_hold | input | HOLD_W | Data hold cycles after a write (strobe scheme 1 only) |
| host_req | input | 1 | Request, taken when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = halfword, 0 = single byte |
| host_addr | input | AW | Byte address |
| host_wdata | input | 16 | Write data, already lane aligned |
| host_rdata | output | 16 | Read data, valid with host_done |
| host_done | output | 1 | One-cycle pulse after the access ends |
| mem_addr | output | AW-1 | SRAM halfword address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rw_n | output | 1 | Read/write line, low for write |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_o | output | 16 | Data bus output |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data bus input |

## Verification
The assertions assume that the host holds the request fields and the configuration steady in the cycle a request is accepted. They also assume that a request that arrives during an access can be dropped. The assertions check strobe exclusivity, lane counts and address stability, which hold for any legal input. The directed stimulus changes fields only on the falling clock edge, and it sets the configuration before it raises `host_req`. Only one scenario deliberately asserts a request in the middle of an access, to show that it is dropped.

// File: rtl/bsel_sram_pkg.sv
package bsel_sram_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_WAIT  = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;
endpackage

// File: rtl/bsel_seq.sv
module bsel_seq
  import bsel_sram_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic              mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [HOLD_W-1:0] hold_i,
  output phase_e            phase_o,
  output logic              we_o,
  output logic              mode_o,
  output logic              load_o,
  output logic              last_o
);
  localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              we_q, mode_q;
  logic [WAIT_W-1:0] wait_q;
  logic [HOLD_W-1:0] hold_q;
  logic              load_en;
  logic              last;

  assign load_en = start_i && (ph_q == PH_IDLE);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    last  = 1'b0;
    case (ph_q)
      PH_IDLE:  if (start_i) ph_d = PH_SETUP;
      PH_SETUP: begin
        if (wait_q == '0) begin
          ph_d = PH_STRB;
        end else begin
          ph_d  = PH_WAIT;
          cnt_d = CNT_W'(wait_q);
        end
      end
      PH_WAIT: begin
        if (cnt_q == CNT_W'(1)) ph_d = PH_STRB;
        else                    cnt_d = cnt_q - CNT_W'(1);
      end
      PH_STRB: begin
        if (mode_q && we_q && (hold_q != '0)) begin
          ph_d  = PH_HOLD;
          cnt_d = CNT_W'(hold_q);
        end else begin
          ph_d = PH_IDLE;
          last = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == CNT_W'(1)) begin
          ph_d = PH_IDLE;
          last = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      mode_q <= 1'b0;
      wait_q <= '0;
      hold_q <= '0;
    end else if (load_en) begin
      we_q   <= we_i;
      mode_q <= mode_i;
      wait_q <= wait_i;
      hold_q <= hold_i;
    end
  end

  assign phase_o = ph_q;
  assign we_o    = we_q;
  assign mode_o  = mode_q;
  assign load_o  = load_en;
  assign last_o  = last;

  // R6: hold cycles only exist for writes under the read/write-strobe scheme
  p_hold_only_m1w_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLD) |-> (mode_q && we_q));
  // R2: a running wait or hold countdown never sits at zero
  p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_WAIT) || (ph_q == PH_HOLD)) |-> (cnt_q != '0));
endmodule

// File: rtl/bsel_lane.sv
module bsel_lane
  import bsel_sram_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [AW-2:0]     mem_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [AW-2:0]     addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  sel_q, sel_d;
  logic              word_q;

  // bit 0 = lower lane, bit 1 = upper lane
  always_comb begin
    if (word_i) sel_d = '1;
    else        sel_d = addr_i[0] ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
      word_q  <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_i[AW-1:1];
      wdata_q <= wdata_i;
      sel_q   <= sel_d;
      word_q  <= word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (cap_i) rdata_q <= dq_i;
  end

  assign mem_addr_o = addr_q;
  assign dq_o       = wdata_q;
  assign sel_o      = sel_q;
  assign rdata_o    = rdata_q;

  // R7: a byte access uses exactly one lane, a halfword access both
  p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !word_q) |-> $onehot(sel_q));
  p_word_two_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && word_q) |-> ($countones(sel_q) == 2));
endmodule

// File: rtl/bsel_strobe.sv
module bsel_strobe
  import bsel_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic             we_i,
  input  logic             mode_i,
  input  logic [LANES-1:0] sel_i,
  output logic             cs_n_o,
  output logic             rd_n_o,
  output logic             rw_n_o,
  output logic             ub_n_o,
  output logic             lb_n_o,
  output logic             oe_o
);
  logic active, inner, sel_win, rw_low;

  always_comb begin
    active  = (phase_i != PH_IDLE);
    inner   = (phase_i == PH_WAIT) || (phase_i == PH_STRB);
    sel_win = mode_i ? active : inner;
    rw_low  = we_i && (mode_i ? inner : active);
  end

  assign cs_n_o = !active;
  assign rd_n_o = !(!we_i && inner);
  assign rw_n_o = !rw_low;
  assign ub_n_o = !(sel_i[1] && sel_win);
  assign lb_n_o = !(sel_i[0] && sel_win);
  assign oe_o   = we_i && active;

  // R8: the bus is never driven while the read strobe is active
  p_no_rd_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_o && !rd_n_o));
  // R4: read strobe and write line are never low together
  p_rw_rd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rw_n_o && !rd_n_o));
  // R5: byte selects never go low outside chip select
  p_sel_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ub_n_o || !lb_n_o) |-> !cs_n_o);
endmodule

// File: rtl/bsel_sram_if.sv
module bsel_sram_if
  import bsel_sram_pkg::*;
#(
  parameter int AW     = 20,
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rw_strobe,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [AW-2:0]     mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_rw_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic [1:0]       rst_sync_q;
  logic             rst_q;
  phase_e           phase;
  logic             we_q, mode_q, load, last;
  logic [LANES-1:0] sel;
  logic             done_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  bsel_seq #(.WAIT_W(WAIT_W), .HOLD_W(HOLD_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .start_i (host_req),
    .we_i    (host_we),
    .mode_i  (cfg_rw_strobe),
    .wait_i  (cfg_wait),
    .hold_i  (cfg_hold),
    .phase_o (phase),
    .we_o    (we_q),
    .mode_o  (mode_q),
    .load_o  (load),
    .last_o  (last)
  );

  bsel_lane #(.AW(AW)) u_lane (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_i     (load),
    .busy_i     (phase != PH_IDLE),
    .addr_i     (host_addr),
    .word_i     (host_word),
    .wdata_i    (host_wdata),
    .cap_i      ((phase == PH_STRB) && !we_q),
    .dq_i       (mem_dq_i),
    .mem_addr_o (mem_addr),
    .dq_o       (mem_dq_o),
    .sel_o      (sel),
    .rdata_o    (host_rdata)
  );

  bsel_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_q),
    .phase_i (phase),
    .we_i    (we_q),
    .mode_i  (mode_q),
    .sel_i   (sel),
    .cs_n_o  (mem_cs_n),
    .rd_n_o  (mem_rd_n),
    .rw_n_o  (mem_rw_n),
    .ub_n_o  (mem_ub_n),
    .lb_n_o  (mem_lb_n),
    .oe_o    (mem_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) done_q <= 1'b0;
    else        done_q <= last;
  end
  assign host_done = done_q;

  // R2: done is a single-cycle pulse that directly follows an access cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_q)
    host_done |=> !host_done);
  p_done_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_q)
    host_done |-> ($past(!mem_cs_n) && mem_cs_n));
  // R10: address is steady across consecutive access cycles
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

// File: tb/bsel_sram_if_tb.sv
module bsel_sram_if_tb;
  localparam int AW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rw_strobe = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic [1:0]  cfg_hold = '0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic        host_word = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_done;
  logic [AW-2:0] mem_addr;
  logic        mem_cs_n, mem_rd_n, mem_rw_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bsel_sram_if #(.AW(AW), .WAIT_W(4), .HOLD_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rw_strobe(cfg_rw_strobe), .cfg_wait(cfg_wait),
    .cfg_hold(cfg_hold), .host_req(host_req), .host_we(host_we), .host_word(host_word),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_rw_n(mem_rw_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp<=50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] pins();
    return {mem_cs_n, mem_rd_n, mem_rw_n, mem_ub_n, mem_lb_n, mem_dq_oe, host_done};
  endfunction

  // expected {cs_n, rd_n, rw_n, ub_n, lb_n, oe, done} for access cycle k
  function automatic logic [6:0] expect_pins(logic mode, logic we, logic word, logic a0,
                                              int w, int len, int k);
    logic inner, win, rd, rw, su, sl;
    if (k == len) return 7'b1111101;
    inner = (k >= 1) && (k <= w + 1);
    win   = mode ? 1'b1 : inner;
    rd    = !we && inner;
    rw    = mode ? (we && inner) : we;
    su    = word || a0;
    sl    = word || !a0;
    return {1'b0, !rd, !rw, !(su && win), !(sl && win), we, 1'b0};
  endfunction

  task automatic run_op(string tag, logic mode, logic we, logic word, logic [AW-1:0] addr,
                        logic [15:0] wd, int w, int h, logic [15:0] din, bit stray);
    int len;
    len = 2 + w + ((mode && we) ? h : 0);
    @(negedge clk);
    cfg_rw_strobe = mode; cfg_wait = 4'(w); cfg_hold = 2'(h);
    host_we = we; host_word = word; host_addr = addr; host_wdata = wd; mem_dq_i = din;
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (stray && k == 1) begin
        host_req = 1'b1; host_addr = addr ^ 20'h00F0F; host_we = !we;
      end else if (stray && k == 2) begin
        host_req = 1'b0;
      end
      check({tag, " R2 pins"}, 32'(pins()), 32'(expect_pins(mode, we, word, addr[0], w, len, k)));
      if (k < len) begin
        check({tag, " R10 addr"}, 32'(mem_addr), 32'(addr[AW-1:1]));
        if (we) check({tag, " R8 dq_o"}, 32'(mem_dq_o), 32'(wd));
      end else if (!we) begin
        check({tag, " R9 rdata"}, 32'(host_rdata), 32'(din));
      end
      @(negedge clk);
    end
    if (stray) begin
      for (int k = 0; k < 3; k++) begin
        check({tag, " R11 no restart"}, 32'(mem_cs_n), 32'd1);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    // R1 during and after reset
    #1;
    check("R1 in reset", 32'(pins()), 32'(7'b1111100));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 32'(pins()), 32'(7'b1111100));
  endtask

  task automatic t_m0_write_word();
    run_op("R3 R7 m0 wr word", 1'b0, 1'b1, 1'b1, 20'h12344, 16'hA55A, 2, 0, 16'h0, 1'b0);
  endtask

  task automatic t_m0_write_low_hold_ignored();
    run_op("R3 R7 R12 m0 wr lo", 1'b0, 1'b1, 1'b0, 20'h00010, 16'h00C3, 0, 3, 16'h0, 1'b0);
  endtask

  task automatic t_m0_read_high();
    run_op("R4 R7 R9 m0 rd hi", 1'b0, 1'b0, 1'b0, 20'h3FFF1, 16'h0, 1, 0, 16'hBE00, 1'b0);
  endtask

  task automatic t_m1_write_word_hold();
    run_op("R5 R6 R8 m1 wr word", 1'b1, 1'b1, 1'b1, 20'h0ABCE, 16'h5AA5, 1, 2, 16'h0, 1'b0);
  endtask

  task automatic t_m1_write_high_nohold();
    run_op("R5 R6 R7 m1 wr hi", 1'b1, 1'b1, 1'b0, 20'h00003, 16'h7700, 3, 0, 16'h0, 1'b0);
  endtask

  task automatic t_m1_write_low_max_hold();
    run_op("R6 R8 m1 wr lo h3", 1'b1, 1'b1, 1'b0, 20'h00100, 16'h0011, 0, 3, 16'h0, 1'b0);
  endtask

  task automatic t_m1_read_hold_ignored();
    run_op("R5 R9 R12 m1 rd word", 1'b1, 1'b0, 1'b1, 20'h22222, 16'h0, 2, 3, 16'hC0DE, 1'b0);
  endtask

  task automatic t_m0_read_long_wait();
    run_op("R4 R9 m0 rd w15", 1'b0, 1'b0, 1'b1, 20'h55554, 16'h0, 15, 0, 16'h1357, 1'b0);
  endtask

  task automatic t_req_while_busy();
    run_op("R11 busy req", 1'b0, 1'b1, 1'b1, 20'h0F0F0, 16'h2468, 3, 0, 16'h0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_m0_write_word();
    t_m0_write_low_hold_ignored();
    t_m0_read_high();
    t_m1_write_word_hold();
    t_m1_write_high_nohold();
    t_m1_write_low_max_hold();
    t_m1_read_hold_ignored();
    t_m0_read_long_wait();
    t_req_while_busy();
    repeat (2) @(negedge clk);
    check("R1 idle at end", 32'(pins()), 32'(7'b1111100));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule